// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with System Masking

This block gathers device interrupt lines and per-processor software interrupts for a cluster of up to four processors. For each processor it produces a 4-bit priority level, which is the highest priority that is currently pending for that processor. Device interrupts pass through a system mask before they reach any processor. Bit 31 of that mask blocks every device source at once. All device interrupts are undirected and go to a single target processor, which software selects through a routing register.

Software reaches the block through a simple register bus. Addresses are byte addresses. The page field `addr[14:12]` selects the register block: pages 0 to NCPU-1 are the per-processor blocks and page NCPU is the system block. The offset field `addr[11:0]` selects a register within the page.

- Per-processor page offsets: 0x0 is pending (read only), 0x4 is clear (write only) and 0x8 is set (write only).
- System page offsets: 0x0 is pending, 0x4 is mask (read only), 0x8 is mask-clear, 0xC is mask-set and 0x10 is target.
- The set and clear registers act only on bits written as one.
- Reads go through a two-state bus machine. `BUS_IDLE` moves to `BUS_READ` when a read strobe arrives. `BUS_READ` stays in `BUS_READ` on another read strobe and returns to `BUS_IDLE` otherwise. The read-valid output is high only while the machine is in `BUS_READ`.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset the system mask reads 0xFFFFFFFF (every source disabled, including mask-all), the target reads 0, every software pending bit is 0 and every level output is 0.
- R2: A write to a processor's set register (offset 0x8) sets software pending bit 16+n for each one in write bits 31:16. A write to its clear register (offset 0x4) clears those bits. Zero bits and write bits 15:0 change nothing.
- R3: A processor's pending register returns software pending in bits 31:16. Bits 15:0 return the device levels routed to that processor, with bit n set when a device source of level n is pending and enabled for it.
- R4: Writing one to a bit of the mask-clear register (0x8) clears that mask bit, which enables the source. Writing one to a bit of the mask-set register (0xC) sets that mask bit, which disables the source. Zero bits leave the mask unchanged.
- R5: The system pending register returns the device lines ANDed with the inverted mask. Bit 31 always reads 0.
- R6: While mask bit 31 is set, no device source contributes to any level output or to any hard pending bit. The system pending register is not affected by this bit.
- R7: The target register can be read and written. Device levels reach only the processor whose number the target register holds.
- R8: The device bits map to levels as follows. Any other bit maps to no level.

  | Device bit | Source | Level |
  |---|---|---|
  | 7 | slot 0 | 2 |
  | 8 | slot 1 | 3 |
  | 18 | SCSI | 4 |
  | 9 | slot 2 | 5 |
  | 16 | ethernet | 6 |
  | 10 | slot 3 | 7 |
  | 20 | video | 8 |
  | 11 | slot 4 | 9 |
  | 30 | module error | 9 |
  | 19 | system timer | 10 |
  | 12 | slot 5 | 11 |
  | 22 | floppy | 11 |
  | 14 | keyboard/mouse | 12 |
  | 15 | serial | 12 |
  | 13 | slot 6 | 13 |
  | 17 | audio | 13 |

- R9: Each level output is the highest level among the processor's software interrupts 1 to 15 and its routed device levels. It is 0 when nothing is pending, and software interrupt 0 never raises it. The level is registered one cycle after its inputs change.
- R10: Read data and read-valid appear one cycle after the read strobe. Addresses outside the mapped registers read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | 32 | Device interrupt lines, indexed by system bit |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 15 | Byte address: page in bits 14:12, offset in bits 11:0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| cpu_level_o | output | 16 | Per-processor level, 4 bits each, processor c at bits 4c+3:4c |

## Verification
A register write takes effect at the clock edge that samples it. A change on a device line or in a register reaches a level output at the following edge, so every level check waits two full cycles after the stimulus and samples on a falling edge. A read sampled at edge k returns its data with read-valid during the cycle after edge k. The driver pushes each expected word into a queue when it issues the read. A monitor pops one entry on each falling edge where read-valid is high, so every response is matched to the read that asked for it.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
    localparam int REG_W        = 32;
    localparam int SOFT_LSB     = 16;
    localparam int NLVL         = 16;
    localparam int LVL_W        = $clog2(NLVL);
    localparam int MASK_ALL_BIT = 31;

    localparam int OFS_CPU_PEND = 'h0;
    localparam int OFS_CPU_CLR  = 'h4;
    localparam int OFS_CPU_SET  = 'h8;
    localparam int OFS_SYS_PEND = 'h0;
    localparam int OFS_SYS_MASK = 'h4;
    localparam int OFS_SYS_CLR  = 'h8;
    localparam int OFS_SYS_SET  = 'hC;
    localparam int OFS_SYS_TGT  = 'h10;

    typedef enum logic [0:0] {BUS_IDLE, BUS_READ} bus_state_e;

    // Device bit to priority level; 0 means the bit raises no level.
    function automatic logic [LVL_W-1:0] src_level(input int bitpos);
        case (bitpos)
            7:       return LVL_W'(2);
            8:       return LVL_W'(3);
            18:      return LVL_W'(4);
            9:       return LVL_W'(5);
            16:      return LVL_W'(6);
            10:      return LVL_W'(7);
            20:      return LVL_W'(8);
            11, 30:  return LVL_W'(9);
            19:      return LVL_W'(10);
            12, 22:  return LVL_W'(11);
            14, 15:  return LVL_W'(12);
            13, 17:  return LVL_W'(13);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] idx_o
);
    // Highest set index above 0; index 0 is never reported.
    always_comb begin
        idx_o = '0;
        for (int i = 1; i < N; i++) begin
            if (req_i[i]) idx_o = W'(i);
        end
    end
endmodule

// File: rtl/mpic_sys_regs.sv
module mpic_sys_regs
    import mpic_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int TGT_W = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we_i,
    input  logic             set_we_i,
    input  logic             tgt_we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] dev_irq_i,
    output logic [REG_W-1:0] mask_o,
    output logic [TGT_W-1:0] target_o,
    output logic [REG_W-1:0] dev_pend_o,
    output logic [NLVL-1:0]  dev_lvl_o
);
    logic [REG_W-1:0] mask_q;
    logic [TGT_W-1:0] tgt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            tgt_q  <= '0;
        end else begin
            if (clr_we_i)      mask_q <= mask_q & ~wdata_i;
            else if (set_we_i) mask_q <= mask_q | wdata_i;
            if (tgt_we_i)      tgt_q  <= wdata_i[TGT_W-1:0];
        end
    end

    localparam logic [REG_W-1:0] ALL_BIT = REG_W'(1) << MASK_ALL_BIT;

    assign dev_pend_o = dev_irq_i & ~mask_q & ~ALL_BIT;
    assign mask_o     = mask_q;
    assign target_o   = tgt_q;

    always_comb begin
        dev_lvl_o = '0;
        if (!mask_q[MASK_ALL_BIT]) begin
            for (int b = 0; b < REG_W; b++) begin
                if (dev_pend_o[b]) dev_lvl_o[src_level(b)] = 1'b1;
            end
        end
        dev_lvl_o[0] = 1'b0;
    end

    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((mask_q & $past(wdata_i)) == '0));
    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i && !clr_we_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
    assert_mask_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i || set_we_i) |=> ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i))));
    assert_target_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_we_i |=> $stable(tgt_q));
endmodule

// File: rtl/mpic_cpu_port.sv
module mpic_cpu_port
    import mpic_pkg::*;
#(
    parameter int CPU_ID = 0,
    parameter int TGT_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we_i,
    input  logic             set_we_i,
    input  logic [NLVL-1:0]  wsoft_i,
    input  logic [NLVL-1:0]  dev_lvl_i,
    input  logic [TGT_W-1:0] target_i,
    output logic [NLVL-1:0]  soft_o,
    output logic [NLVL-1:0]  hard_o,
    output logic [LVL_W-1:0] level_o
);
    logic [NLVL-1:0]  soft_q;
    logic [NLVL-1:0]  lvl_vec;
    logic [LVL_W-1:0] enc_lvl;
    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        soft_q <= '0;
        else if (clr_we_i) soft_q <= soft_q & ~wsoft_i;
        else if (set_we_i) soft_q <= soft_q | wsoft_i;
    end

    assign hard_o  = (target_i == TGT_W'(CPU_ID)) ? dev_lvl_i : '0;
    assign lvl_vec = soft_q | hard_o;

    mpic_prio_enc #(.N(NLVL), .W(LVL_W)) u_enc (
        .req_i (lvl_vec),
        .idx_o (enc_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= enc_lvl;
    end

    assign soft_o  = soft_q;
    assign level_o = level_q;

    assert_soft_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i && !clr_we_i) |=> ((soft_q & $past(wsoft_i)) == $past(wsoft_i)));
    assert_soft_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((soft_q & $past(wsoft_i)) == '0));
    assert_soft_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i || clr_we_i) |=> ((soft_q & ~$past(wsoft_i)) == ($past(soft_q) & ~$past(wsoft_i))));
    assert_level_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != '0) |-> (((($past(lvl_vec) >> level_q) & NLVL'(1)) != '0)
                             && ((($past(lvl_vec) >> level_q) >> 1) == '0)));
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mpic_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_W-1:0]       dev_irq_i,
    input  logic                   bus_wr_i,
    input  logic                   bus_rd_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [REG_W-1:0]       bus_wdata_i,
    output logic [REG_W-1:0]       bus_rdata_o,
    output logic                   bus_rvalid_o,
    output logic [NCPU*LVL_W-1:0]  cpu_level_o
);
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [PG_W-1:0]   page;
    logic [PAGE_W-1:0] off;
    logic              sys_sel;
    logic              sys_clr_we, sys_set_we, sys_tgt_we;
    logic [NCPU-1:0]   cpu_clr_we, cpu_set_we;

    logic [REG_W-1:0]  mask_w, dev_pend_w;
    logic [TGT_W-1:0]  target_w;
    logic [NLVL-1:0]   dev_lvl_w;
    logic [NLVL-1:0]   soft_arr [NCPU];
    logic [NLVL-1:0]   hard_arr [NCPU];

    assign page    = bus_addr_i[ADDR_W-1:PAGE_W];
    assign off     = bus_addr_i[PAGE_W-1:0];
    assign sys_sel = (page == PG_W'(NCPU));

    assign sys_clr_we = bus_wr_i && sys_sel && (off == PAGE_W'(OFS_SYS_CLR));
    assign sys_set_we = bus_wr_i && sys_sel && (off == PAGE_W'(OFS_SYS_SET));
    assign sys_tgt_we = bus_wr_i && sys_sel && (off == PAGE_W'(OFS_SYS_TGT));

    mpic_sys_regs #(.NCPU(NCPU), .TGT_W(TGT_W)) u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_we_i   (sys_clr_we),
        .set_we_i   (sys_set_we),
        .tgt_we_i   (sys_tgt_we),
        .wdata_i    (bus_wdata_i),
        .dev_irq_i  (dev_irq_i),
        .mask_o     (mask_w),
        .target_o   (target_w),
        .dev_pend_o (dev_pend_w),
        .dev_lvl_o  (dev_lvl_w)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign cpu_clr_we[c] = bus_wr_i && (page == PG_W'(c)) && (off == PAGE_W'(OFS_CPU_CLR));
        assign cpu_set_we[c] = bus_wr_i && (page == PG_W'(c)) && (off == PAGE_W'(OFS_CPU_SET));

        mpic_cpu_port #(.CPU_ID(c), .TGT_W(TGT_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_we_i  (cpu_clr_we[c]),
            .set_we_i  (cpu_set_we[c]),
            .wsoft_i   (bus_wdata_i[REG_W-1:SOFT_LSB]),
            .dev_lvl_i (dev_lvl_w),
            .target_i  (target_w),
            .soft_o    (soft_arr[c]),
            .hard_o    (hard_arr[c]),
            .level_o   (cpu_level_o[c*LVL_W +: LVL_W])
        );
    end

    // Read data selection
    logic [REG_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (sys_sel) begin
            case (off)
                PAGE_W'(OFS_SYS_PEND): rd_mux = dev_pend_w;
                PAGE_W'(OFS_SYS_MASK): rd_mux = mask_w;
                PAGE_W'(OFS_SYS_TGT):  rd_mux = REG_W'(target_w);
                default:               rd_mux = '0;
            endcase
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (page == PG_W'(c) && off == PAGE_W'(OFS_CPU_PEND))
                    rd_mux = {soft_arr[c], hard_arr[c]};
            end
        end
    end

    // Bus read state machine
    bus_state_e       state_q, state_d;
    logic [REG_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = bus_rd_i ? BUS_READ : BUS_IDLE;
            BUS_READ: state_d = bus_rd_i ? BUS_READ : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_mux;
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = (state_q == BUS_READ);

    assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);
    assert_rvalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> !bus_rvalid_o);
endmodule

// File: tb/mp_irq_ctrl_test.sv
module mp_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int WDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] dev;
    logic        wr, rd;
    logic [14:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid;
    logic [NCPU*4-1:0] lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    mp_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dev_irq_i(dev), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bus_rvalid_o(rvalid), .cpu_level_o(lvl)
    );

    typedef struct { logic [31:0] data; string tag; } exp_t;
    exp_t q[$];
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Requirement model
    logic [31:0] mask_m;
    logic [1:0]  tgt_m;
    logic [15:0] soft_m [NCPU];
    logic [31:0] dev_m;

    function automatic logic [3:0] ref_level(input int b);
        case (b)
            7: return 2;   8: return 3;   18: return 4;  9: return 5;
            16: return 6;  10: return 7;  20: return 8;  11: return 9;
            30: return 9;  19: return 10; 12: return 11; 22: return 11;
            14: return 12; 15: return 12; 13: return 13; 17: return 13;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] ref_devlv();
        logic [15:0] v = '0;
        if (!mask_m[31])
            for (int b = 0; b < 31; b++)
                if (dev_m[b] && !mask_m[b]) v[ref_level(b)] = 1'b1;
        v[0] = 1'b0;
        return v;
    endfunction

    function automatic logic [15:0] ref_hard(input int c);
        return (c == int'(tgt_m)) ? ref_devlv() : 16'h0;
    endfunction

    function automatic logic [3:0] ref_cpu_level(input int c);
        logic [15:0] v = soft_m[c] | ref_hard(c);
        logic [3:0] r = 0;
        for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
        return r;
    endfunction

    function automatic logic [14:0] a_cpu(input int c, input int o);
        return 15'((c << 12) | o);
    endfunction

    function automatic logic [14:0] a_sys(input int o);
        return 15'((4 << 12) | o);
    endfunction

    // Monitor: pop and compare on read-valid
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            exp_t e;
            vectors++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected read data: actual=%h expected=none", rdata);
            end else begin
                e = q.pop_front();
                if (rdata !== e.data) begin
                    fails++;
                    $display("FAIL %s read: actual=%h expected=%h", e.tag, rdata, e.data);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [14:0] a, input logic [31:0] e, input string tag);
        exp_t x;
        x.data = e; x.tag = tag;
        q.push_back(x);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_lvl(input int c, input logic [3:0] e, input string tag);
        vectors++;
        if (lvl[c*4 +: 4] !== e) begin
            fails++;
            $display("FAIL %s level cpu%0d: actual=%0d expected=%0d", tag, c, lvl[c*4 +: 4], e);
        end
    endtask

    task automatic check_all(input string tag);
        idle(2);
        for (int c = 0; c < NCPU; c++) check_lvl(c, ref_cpu_level(c), tag);
        for (int c = 0; c < NCPU; c++) do_read(a_cpu(c, 0), {soft_m[c], ref_hard(c)}, tag);
        do_read(a_sys('h0), dev_m & ~mask_m & 32'h7FFF_FFFF, tag);
        do_read(a_sys('h4), mask_m, tag);
        do_read(a_sys('h10), {30'h0, tgt_m}, tag);
    endtask

    task automatic sys_clr(input logic [31:0] d); do_write(a_sys('h8), d); mask_m &= ~d; endtask
    task automatic sys_set(input logic [31:0] d); do_write(a_sys('hC), d); mask_m |= d; endtask
    task automatic sys_tgt(input logic [1:0] t); do_write(a_sys('h10), {30'h0, t}); tgt_m = t; endtask
    task automatic cpu_set(input int c, input logic [31:0] d); do_write(a_cpu(c, 'h8), d); soft_m[c] |= d[31:16]; endtask
    task automatic cpu_clr(input int c, input logic [31:0] d); do_write(a_cpu(c, 'h4), d); soft_m[c] &= ~d[31:16]; endtask
    task automatic set_dev(input logic [31:0] d); dev = d; dev_m = d; endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr = 0; rd = 0; addr = '0; wdata = '0; dev = '0;
        mask_m = '1; tgt_m = 0; dev_m = '0;
        for (int c = 0; c < NCPU; c++) soft_m[c] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        check_all("R1");                         // reset state
        set_dev(32'h000C_4000);                  // timer, SCSI, keyboard
        check_all("R5");                         // all masked: pending reads 0
        sys_clr(32'h000C_0000);                  // enable timer and SCSI
        check_all("R4");
        check_lvl(0, 4'd0, "R6");                // mask-all still set
        sys_clr(32'h0);                          // zero bits: no change
        check_all("R4");
        sys_clr(32'h8000_0000);                  // drop mask-all
        check_all("R6");
        check_lvl(0, 4'd10, "R3");
        sys_tgt(2'd2);
        check_all("R7");
        check_lvl(2, 4'd10, "R7");
        sys_set(32'h0008_0000);                  // disable timer
        check_all("R4");
        check_lvl(2, 4'd4, "R4");
        sys_set(32'h0);
        check_all("R4");

        cpu_set(1, 32'h0020_FFFF);               // soft 5, low bits ignored
        check_all("R2");
        cpu_set(1, 32'h4000_0000);               // soft 14
        check_all("R9");
        check_lvl(1, 4'd14, "R9");
        cpu_clr(1, 32'h4000_0000);
        check_all("R2");
        cpu_clr(1, 32'h0);
        check_all("R2");
        cpu_set(3, 32'h0001_0000);               // soft 0: no level
        check_all("R9");
        check_lvl(3, 4'd0, "R9");

        sys_tgt(2'd0);
        sys_clr(32'hFFFF_FFFF);
        for (int b = 0; b < 32; b++) begin
            set_dev(32'h1 << b);
            idle(2);
            check_lvl(0, ref_level(b), "R8");
            check_lvl(1, ref_cpu_level(1), "R7");
        end
        check_all("R5");                         // bit 31 reads 0

        set_dev(32'h0002_1000);                  // slot 5 + audio
        check_all("R9");
        check_lvl(0, 4'd13, "R9");
        cpu_set(0, 32'h8000_0000);               // soft 15 wins
        check_all("R9");
        check_lvl(0, 4'd15, "R9");

        do_write(15'h5008, 32'hFFFF_FFFF);       // unmapped page
        do_write(a_cpu(0, 'h0), 32'hFFFF_FFFF);  // read-only pending
        do_read(15'h5000, 32'h0, "R10");
        do_read(a_sys('h14), 32'h0, "R10");
        check_all("R10");

        sys_set(32'h8000_0000);                  // mask-all again
        check_all("R6");
        cpu_clr(0, 32'hFFFF_0000);
        check_all("R6");
        check_lvl(0, 4'd0, "R6");

        idle(4);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing responses: actual=%0d expected=0", q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule